// File: doc/BRIEF.md
# UART Receive Buffer and Line Status

This block sits between a serial receiver and the register bus of a 16550-class UART. Every character the receiver delivers arrives with three tags (parity error, framing error, break). The block stores the character and its tags together. With buffering on, storage is a queue of `DEPTH` entries. With buffering off, storage is a single holding register. The bus reads the oldest character through `rbr_data` and strobes `rbr_rd` to consume it.

The block also forms the 8-bit line status word. The error bits describe the character at the head of the store, not the newest arrival. A summary bit tracks tagged characters anywhere in the queue. A strobe on `lsr_rd` marks a status read and applies the clear-on-read effects. The two transmit bits are registered from empty and full indications supplied by the transmit path.

Top module: `uart_rx_status`

## Requirements
- R1: `lsr` bit positions are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 holding-empty, 6 transmitter-empty, 7 queue-error summary.
- R2: While reset is held, and on the first cycle after it, `lsr` reads 0x60 when the transmit inputs report idle.
- R3: Bits 2, 3 and 4 take on the tags of a character in the same cycle that character becomes the head of the store. Tags of characters behind the head do not show.
- R4: A status read clears bits 1 to 4 at that clock edge. A set that occurs in the same cycle takes priority over the clear.
- R5: With buffering on, bit 7 sets when a tagged character enters the queue. With buffering off, bit 7 stays 0.
- R6: A status read clears bit 7 only when no entry behind the head carries a tag. Otherwise bit 7 stays 1.
- R7: With buffering on, a character that arrives while all `DEPTH` (default 16) entries are full, with no read in the same cycle, is discarded. The stored entries are kept and bit 1 sets.
- R8: Bit 0 is 1 exactly while at least one character is stored.
- R9: With buffering off, a character that arrives while the holding register is occupied and unread replaces it and sets bit 1.
- R10: Bit 5 is registered each cycle. It follows `tx_fifo_full` when both `prog_thre_en` and `fifo_en` are 1, and follows `tx_hold_empty` otherwise. Bit 6 is registered as `tx_hold_empty & tx_shift_empty`.
- R11: Any change of `fifo_en` empties the store at the next edge, drops an arrival in that cycle, and clears bit 7.
- R12: `rbr_data` presents stored characters in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 selects the queue, 0 selects the single holding register |
| prog_thre_en | input | 1 | Programmable holding-empty mode |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag |
| rx_ferr | input | 1 | Framing error tag |
| rx_brk | input | 1 | Break tag |
| rbr_rd | input | 1 | Consume the head character |
| lsr_rd | input | 1 | Status word is being read |
| tx_hold_empty | input | 1 | Transmit holding register or transmit queue empty |
| tx_fifo_full | input | 1 | Transmit queue full |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rbr_data | output | 8 | Head character |
| lsr | output | 8 | Line status word |

## Verification
The bench places a tagged character behind a clean one. A design that shows the newest tags instead of the head's would raise bit 2 too early. A design that clears the summary bit unconditionally would drop bit 7 while the tagged entry still waits. The bench also offers a 17th character to a full queue. It then drains the queue through the scoreboard, so overwriting an entry or storing the extra character shows up as a data mismatch. Further tests cover a tagged arrival coinciding with a status read, a mode change with data still stored, overwrite in holding-register mode, and the transmit bit selection.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive buffer and line status block.
// Assumes an 8-bit character with three per-character receive tags.
package uart_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    // Status word bit positions, decoded by the bus side
    localparam int LS_DR   = 0;
    localparam int LS_OE   = 1;
    localparam int LS_PE   = 2;
    localparam int LS_FE   = 3;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_RFE  = 7;

    function automatic logic entry_tagged(rx_entry_t e);
        return e.perr | e.ferr | e.brk;
    endfunction

endpackage

// File: rtl/rx_store.sv
// Character store: a DEPTH-entry queue, or a single holding register when
// fifo_en is low. Each entry keeps its receive tags. Also reports when a new
// character becomes the head, and a count of tagged entries.
// Assumes DEPTH >= 2; flush takes priority over every other action.
module rx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       flush,
    input  logic       wr_req,
    input  rx_entry_t  wr_entry,
    input  logic       rd_req,
    output logic [7:0] head_data,
    output logic       has_data,
    output logic       ovr,
    output logic       head_load,
    output rx_entry_t  head_next,
    output logic       tag_in,
    output logic       behind_clean
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    rx_entry_t          mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr, rd_ptr_nx;
    logic [CNT_W-1:0]   count, tag_cnt, count_n, tag_cnt_n, cap;
    logic               pop_eff, full, push_acc, overwrite, head_tag;
    rx_entry_t          head;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head      = mem[rd_ptr];
    assign rd_ptr_nx = bump(rd_ptr);
    assign head_data = (count != '0) ? head.data : 8'h00;
    assign has_data  = (count != '0);
    assign head_tag  = (count != '0) && entry_tagged(head);

    // Decide what happens to the store this cycle
    always_comb begin
        cap       = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        pop_eff   = rd_req && (count != '0) && !flush;
        full      = (count == cap);
        push_acc  = wr_req && !flush && (!full || pop_eff);
        ovr       = wr_req && !flush && full && !pop_eff;
        overwrite = ovr && !fifo_en;
        tag_in    = push_acc && fifo_en && entry_tagged(wr_entry);
    end

    // Identify a character that becomes the head at this edge
    always_comb begin
        head_load = 1'b0;
        head_next = '0;
        if (pop_eff && count > CNT_W'(1)) begin
            head_load = 1'b1;
            head_next = mem[rd_ptr_nx];
        end else if (push_acc && (count == '0 || (pop_eff && count == CNT_W'(1)))) begin
            head_load = 1'b1;
            head_next = wr_entry;
        end else if (overwrite) begin
            head_load = 1'b1;
            head_next = wr_entry;
        end
    end

    // Next occupancy and tagged-entry count
    always_comb begin
        count_n   = count;
        tag_cnt_n = tag_cnt;
        if (push_acc) count_n = count_n + CNT_W'(1);
        if (pop_eff)  count_n = count_n - CNT_W'(1);
        if (push_acc && entry_tagged(wr_entry)) tag_cnt_n = tag_cnt_n + CNT_W'(1);
        if (pop_eff && entry_tagged(head))      tag_cnt_n = tag_cnt_n - CNT_W'(1);
        if (overwrite) begin
            if (entry_tagged(head))     tag_cnt_n = tag_cnt_n - CNT_W'(1);
            if (entry_tagged(wr_entry)) tag_cnt_n = tag_cnt_n + CNT_W'(1);
        end
    end

    assign behind_clean = (tag_cnt == CNT_W'(head_tag));

    // Pointer and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            tag_cnt <= '0;
        end else begin
            if (push_acc) wr_ptr <= bump(wr_ptr);
            if (pop_eff)  rd_ptr <= rd_ptr_nx;
            count   <= count_n;
            tag_cnt <= tag_cnt_n;
        end
    end

    // Entry storage, no reset needed
    always_ff @(posedge clk) begin
        if (push_acc)  mem[wr_ptr] <= wr_entry;
        if (overwrite) mem[rd_ptr] <= wr_entry;
    end

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && fifo_en) |=> (count == CNT_W'(DEPTH))); // R7
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush) |-> (count <= CNT_W'(1))); // R9
    AST_TAGS_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        tag_cnt <= count); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !has_data); // R11
endmodule

// File: rtl/lsr_regs.sv
// Sticky line status flags and the assembled 8-bit status word.
// Assumes the event inputs describe the edge at which they are sampled.
module lsr_regs
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       prog_thre_en,
    input  logic       tx_hold_empty,
    input  logic       tx_fifo_full,
    input  logic       tx_shift_empty,
    input  logic       lsr_rd,
    input  logic       flush,
    input  logic       ovr,
    input  logic       head_load,
    input  rx_entry_t  head_next,
    input  logic       tag_in,
    input  logic       behind_clean,
    input  logic       has_data,
    output logic [7:0] lsr
);
    logic oe_q, pe_q, fe_q, bi_q, rfe_q, thre_q, temt_q;
    logic ld_pe, ld_fe, ld_bi;

    assign ld_pe = head_load && head_next.perr;
    assign ld_fe = head_load && head_next.ferr;
    assign ld_bi = head_load && head_next.brk;

    // Error flags: set by events, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
            bi_q <= 1'b0;
        end else begin
            oe_q <= ovr   || (oe_q && !lsr_rd);
            pe_q <= ld_pe || (pe_q && !lsr_rd);
            fe_q <= ld_fe || (fe_q && !lsr_rd);
            bi_q <= ld_bi || (bi_q && !lsr_rd);
        end
    end

    // Queue-error summary with conditional clear
    always_ff @(posedge clk) begin
        if (!rst_n || flush)           rfe_q <= 1'b0;
        else if (tag_in)               rfe_q <= 1'b1;
        else if (lsr_rd && behind_clean) rfe_q <= 1'b0;
    end

    // Registered transmit status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_q <= 1'b1;
            temt_q <= 1'b1;
        end else begin
            thre_q <= (prog_thre_en && fifo_en) ? tx_fifo_full : tx_hold_empty;
            temt_q <= tx_hold_empty && tx_shift_empty;
        end
    end

    // Assemble the status word
    always_comb begin
        lsr          = '0;
        lsr[LS_DR]   = has_data;
        lsr[LS_OE]   = oe_q;
        lsr[LS_PE]   = pe_q;
        lsr[LS_FE]   = fe_q;
        lsr[LS_BI]   = bi_q;
        lsr[LS_THRE] = thre_q;
        lsr[LS_TEMT] = temt_q;
        lsr[LS_RFE]  = rfe_q;
    end

    AST_OE_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> lsr[LS_OE]); // R7
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ovr && !head_load) |=> (lsr[4:1] == 4'b0000)); // R4
    AST_RFE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !behind_clean && !flush && lsr[LS_RFE]) |=> lsr[LS_RFE]); // R6
    AST_RFE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lsr[LS_RFE]); // R11
endmodule

// File: rtl/uart_rx_status.sv
// Top: receive character store plus line status word for a 16550-class UART.
// Assumes one-cycle strobes for rbr_rd and lsr_rd from the bus decoder.
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       prog_thre_en,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    input  logic       tx_hold_empty,
    input  logic       tx_fifo_full,
    input  logic       tx_shift_empty,
    output logic [7:0] rbr_data,
    output logic [7:0] lsr
);
    logic      mode_q, flush, has_data, ovr, head_load, tag_in, behind_clean;
    rx_entry_t wr_entry, head_next;

    assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_char};
    assign flush    = (fifo_en != mode_q);

    // Remember the buffering mode to detect changes
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b1;
        else        mode_q <= fifo_en;
    end

    rx_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .flush        (flush),
        .wr_req       (rx_valid),
        .wr_entry     (wr_entry),
        .rd_req       (rbr_rd),
        .head_data    (rbr_data),
        .has_data     (has_data),
        .ovr          (ovr),
        .head_load    (head_load),
        .head_next    (head_next),
        .tag_in       (tag_in),
        .behind_clean (behind_clean)
    );

    lsr_regs u_lsr (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_en        (fifo_en),
        .prog_thre_en   (prog_thre_en),
        .tx_hold_empty  (tx_hold_empty),
        .tx_fifo_full   (tx_fifo_full),
        .tx_shift_empty (tx_shift_empty),
        .lsr_rd         (lsr_rd),
        .flush          (flush),
        .ovr            (ovr),
        .head_load      (head_load),
        .head_next      (head_next),
        .tag_in         (tag_in),
        .behind_clean   (behind_clean),
        .has_data       (has_data),
        .lsr            (lsr)
    );

    AST_NOFIFO_RFE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !mode_q) |-> !lsr[7]); // R5
    AST_DR_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !flush) |=> lsr[0]); // R8
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;

    logic       clk = 1'b0;
    logic       rst_n, fifo_en, prog_thre_en, rx_valid, rx_perr, rx_ferr, rx_brk;
    logic       rbr_rd, lsr_rd, tx_hold_empty, tx_fifo_full, tx_shift_empty;
    logic [7:0] rx_char, rbr_data, lsr;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [7:0] exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    uart_rx_status #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .prog_thre_en(prog_thre_en),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_brk(rx_brk), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .tx_hold_empty(tx_hold_empty),
        .tx_fifo_full(tx_fifo_full), .tx_shift_empty(tx_shift_empty),
        .rbr_data(rbr_data), .lsr(lsr)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: offers one character and records what the store should hold
    task automatic push(logic [7:0] d, logic p, logic f, logic b, logic also_lsr = 1'b0);
        rx_valid = 1'b1; rx_char = d; rx_perr = p; rx_ferr = f; rx_brk = b; lsr_rd = also_lsr;
        if (fifo_en) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(d);
        end else begin
            if (exp_q.size() == 1) void'(exp_q.pop_front());
            exp_q.push_back(d);
        end
        step();
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0; lsr_rd = 1'b0;
    endtask

    task automatic pop();
        rbr_rd = 1'b1;
        step();
        rbr_rd = 1'b0;
    endtask

    task automatic read_lsr();
        lsr_rd = 1'b1;
        step();
        lsr_rd = 1'b0;
    endtask

    // Monitor: compares the head character against the scoreboard on each consume
    always @(negedge clk) begin
        if (rst_n && rbr_rd) begin
            if (exp_q.size() == 0) check("R12 unexpected read", rbr_data, 8'hxx);
            else check("R12 head order", rbr_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fifo_en = 1'b1; prog_thre_en = 1'b0; rx_valid = 1'b0; rx_char = '0;
        rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0; rbr_rd = 1'b0; lsr_rd = 1'b0;
        tx_hold_empty = 1'b1; tx_fifo_full = 1'b0; tx_shift_empty = 1'b1;
        step(); step();
        check("R2 in reset", lsr, 8'h60);
        rst_n = 1'b1;
        step();
        check("R2 after reset", lsr, 8'h60);

        // R3/R5/R6: tagged character behind a clean one
        push(8'hA1, 0, 0, 0);
        check("R8 data ready, R1 layout", lsr, 8'h61);
        push(8'hB2, 1, 0, 0);
        check("R3 hidden tag, R5 summary set", lsr, 8'hE1);
        push(8'hC3, 0, 0, 0);
        read_lsr();
        check("R6 summary kept", lsr, 8'hE1);
        pop();
        check("R3 tag at head", lsr, 8'hE5);
        read_lsr();
        check("R4 clear, R6 summary cleared", lsr, 8'h61);
        pop(); pop();
        check("R8 empty", lsr, 8'h60);

        // R7: overrun when full
        for (int i = 0; i < DEPTH; i++) push(8'(i + 16), 0, 0, 0);
        check("R7 full no overrun", lsr, 8'h61);
        push(8'hEE, 0, 0, 0);
        check("R7 overrun set", lsr, 8'h63);
        read_lsr();
        check("R4 overrun cleared", lsr, 8'h61);
        for (int i = 0; i < DEPTH; i++) pop();
        check("R7 drained", lsr, 8'h60);

        // Break character carries all three tags
        push(8'h00, 1, 1, 1);
        check("R3 break at head", lsr, 8'hFD);
        read_lsr();
        check("R4 break cleared", lsr, 8'h61);
        pop();

        // R4: arrival coinciding with a status read
        push(8'h5A, 1, 0, 0, 1'b1);
        check("R4 set wins", lsr, 8'hE5);
        read_lsr();
        pop();
        check("R4 settle", lsr, 8'h60);

        // R11: mode change empties the store
        push(8'h77, 0, 1, 0);
        check("R11 before switch", lsr, 8'hE9);
        fifo_en = 1'b0;
        exp_q.delete();
        step();
        check("R11 flushed", lsr, 8'h68);
        read_lsr();
        check("R11 cleared", lsr, 8'h60);

        // R9: holding register overwrite, R5 no summary
        push(8'h11, 0, 0, 0);
        check("R9 held", lsr, 8'h61);
        push(8'h22, 1, 0, 0);
        check("R9 overwrite, R5 no summary", lsr, 8'h67);
        pop();
        check("R8 held read", lsr, 8'h66);
        read_lsr();
        check("R4 non-buffered clear", lsr, 8'h60);

        // R10: transmit status selection
        prog_thre_en = 1'b1; tx_hold_empty = 1'b0; tx_fifo_full = 1'b1;
        step();
        check("R10 buffering off uses empty", lsr, 8'h00);
        fifo_en = 1'b1;
        step();
        check("R10 full reported", lsr, 8'h20);
        prog_thre_en = 1'b0;
        step();
        check("R10 normal empty", lsr, 8'h00);
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b0;
        step();
        check("R10 shift busy", lsr, 8'h20);
        tx_shift_empty = 1'b1;
        step();
        check("R10 all idle", lsr, 8'h60);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule